// File: doc/BRIEF.md
# Multiply-Step Unit with Flag Feedback and Sequencer

The block computes one step of a shift-and-add multiply in a single combinational pass. A step takes a running partial sum, a multiplicand, the current negative and overflow flags, and a 32-bit multiplier register.

- The partial sum is shifted right by one. The exclusive-or of the negative and overflow flags fills the vacated top bit, so the shift keeps the true sign of the previous 33-bit sum.
- The multiplicand is then added, or zero is added, depending on bit 0 of the multiplier register.
- The multiplier register shifts right by one and takes in the bit that fell off the partial sum.
- The step also produces four new condition flags. Software feeds them into the next step.

A sequencer runs the same step from registers after a start pulse. It clears the partial sum and flags and loads the multiplier register. It then issues 32 steps with the multiplicand and one closing step with a zero addend. The high product word is left in the partial-sum register and the low word in the multiplier register. Both are visible on the product outputs and hold there until the next start. The direct step port and the sequencer share one step implementation and work independently of each other.

Top module: `mstep_unit`

## Requirements
- R1: The step sum equals the shifted operand plus the addend, modulo 2^32. In the shifted operand, bit 31 is N xor V of the incoming flags and bits 30..0 are bits 31..1 of the first operand.
- R2: The addend is the multiplicand when bit 0 of the incoming Y value is 1, and zero when it is 0.
- R3: The outgoing Y value is the incoming Y shifted right by one, with bit 0 of the first operand placed in bit 31.
- R4: The flags output is packed as bit 3 = N, bit 2 = Z, bit 1 = V, bit 0 = C. N equals bit 31 of the sum, and Z is 1 exactly when the sum is zero.
- R5: C is the carry out of the unsigned 32-bit addition of shifted operand and addend. V is 1 when that addition overflows as a signed two's-complement addition.
- R6: After reset, busy and done are 0 and both product words are 0.
- R7: A start seen on a clock edge while idle raises busy after that edge. Busy stays high for 33 edges. On the 33rd edge after the start edge, busy falls and done pulses high for exactly one cycle.
- R8: When done is high, {product high, product low} equals the 64-bit two's-complement product of the multiplicand (signed) and the multiplier (unsigned).
- R9: A start asserted while busy is ignored. The running multiplication completes with the operands taken at its own start and keeps its timing.
- R10: While idle and without a start, both product words hold their values whatever the operand inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_op1_i | input | 32 | Direct step: first operand (running partial sum) |
| st_mcand_i | input | 32 | Direct step: multiplicand |
| st_n_i | input | 1 | Direct step: incoming N flag |
| st_v_i | input | 1 | Direct step: incoming V flag |
| st_y_i | input | 32 | Direct step: incoming Y value |
| st_sum_o | output | 32 | Direct step: new partial sum |
| st_y_o | output | 32 | Direct step: new Y value |
| st_flags_o | output | 4 | Direct step: new flags {N,Z,V,C} |
| start_i | input | 1 | Sequencer: begin a multiplication |
| mult_i | input | 32 | Sequencer: multiplier (unsigned) |
| mcand_i | input | 32 | Sequencer: multiplicand (signed) |
| busy_o | output | 1 | Sequencer: multiplication in progress |
| done_o | output | 1 | Sequencer: one-cycle completion pulse |
| prod_hi_o | output | 32 | Sequencer: high product word |
| prod_lo_o | output | 32 | Sequencer: low product word |

## Verification
The corner cases the bench targets are these:

- **Sign recovery through N xor V.** A design that shifts in the raw sum bit instead gives wrong high words for a negative multiplicand, such as -7 or 0x80000000 times 0xFFFFFFFF.
- **Flag edges.** The additions 0x7FFFFFFF plus 1 and 0xFFFFFFFF plus 1 must set V and C respectively. Swapped or misplaced flag bits show up at once in the packed flag word.
- **The closing zero-addend step.** Omitting it, or still adding the multiplicand in it, leaves the product one shift short or adds an extra multiple. The 33-cycle done timing is checked on every clock.
- **A start arriving mid-run.** A design that restarts on it would corrupt both the latency and the product.

// File: rtl/mstep_pkg.sv
package mstep_pkg;
  localparam int unsigned WORD_W = 32;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;
endpackage

// File: rtl/mstep_core.sv
module mstep_core
  import mstep_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic [W-1:0] op1_i,
  input  logic [W-1:0] mcand_i,
  input  logic         n_i,
  input  logic         v_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] y_o,
  output flags_t       flags_o
);
  logic [W-1:0] shifted;
  logic [W-1:0] addend;
  logic [W:0]   wide;

  // restore true sign of previous 33-bit sum
  assign shifted = {n_i ^ v_i, op1_i[W-1:1]};
  assign addend  = y_i[0] ? mcand_i : '0;
  assign wide    = {1'b0, shifted} + {1'b0, addend};
  assign sum_o   = wide[W-1:0];
  assign y_o     = {op1_i[0], y_i[W-1:1]};

  always_comb begin
    flags_o.n = wide[W-1];
    flags_o.z = (wide[W-1:0] == '0);
    flags_o.v = (shifted[W-1] == addend[W-1]) && (wide[W-1] != addend[W-1]);
    flags_o.c = wide[W];
  end
endmodule

// File: rtl/mstep_seq.sv
module mstep_seq
  import mstep_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] mult_i,
  input  logic [W-1:0] mcand_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] prod_hi_o,
  output logic [W-1:0] prod_lo_o
);
  localparam int unsigned CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W);

  logic [W-1:0]  p_q, y_q, m_q;
  logic          n_q, v_q, busy_q, done_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  sum_nxt, y_nxt, step_mcand;
  flags_t        fl_nxt;

  // closing step adds zero
  assign step_mcand = (cnt_q == LAST) ? '0 : m_q;

  mstep_core #(.W(W)) i_core (
    .op1_i  (p_q),
    .mcand_i(step_mcand),
    .n_i    (n_q),
    .v_i    (v_q),
    .y_i    (y_q),
    .sum_o  (sum_nxt),
    .y_o    (y_nxt),
    .flags_o(fl_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_q    <= '0;
      y_q    <= '0;
      m_q    <= '0;
      n_q    <= 1'b0;
      v_q    <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        p_q <= sum_nxt;
        y_q <= y_nxt;
        n_q <= fl_nxt.n;
        v_q <= fl_nxt.v;
        if (cnt_q == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        p_q    <= '0;
        y_q    <= mult_i;
        m_q    <= mcand_i;
        n_q    <= 1'b0;
        v_q    <= 1'b0;
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign prod_hi_o = p_q;
  assign prod_lo_o = y_q;

  // R7
  busy_done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));
  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R7
  start_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(prod_hi_o) && $stable(prod_lo_o)));
  // R9
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cnt_q != LAST) |=> busy_o);
endmodule

// File: rtl/mstep_unit.sv
module mstep_unit
  import mstep_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] st_op1_i,
  input  logic [W-1:0] st_mcand_i,
  input  logic         st_n_i,
  input  logic         st_v_i,
  input  logic [W-1:0] st_y_i,
  output logic [W-1:0] st_sum_o,
  output logic [W-1:0] st_y_o,
  output logic [3:0]   st_flags_o,
  input  logic         start_i,
  input  logic [W-1:0] mult_i,
  input  logic [W-1:0] mcand_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] prod_hi_o,
  output logic [W-1:0] prod_lo_o
);
  flags_t st_flags;

  mstep_core #(.W(W)) i_step (
    .op1_i  (st_op1_i),
    .mcand_i(st_mcand_i),
    .n_i    (st_n_i),
    .v_i    (st_v_i),
    .y_i    (st_y_i),
    .sum_o  (st_sum_o),
    .y_o    (st_y_o),
    .flags_o(st_flags)
  );

  assign st_flags_o = st_flags;

  mstep_seq #(.W(W)) i_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .mult_i   (mult_i),
    .mcand_i  (mcand_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .prod_hi_o(prod_hi_o),
    .prod_lo_o(prod_lo_o)
  );
endmodule

// File: tb/test_mstep_unit.sv
module test_mstep_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] st_op1_i = '0, st_mcand_i = '0, st_y_i = '0;
  logic        st_n_i = 1'b0, st_v_i = 1'b0;
  logic [31:0] st_sum_o, st_y_o;
  logic [3:0]  st_flags_o;
  logic        start_i = 1'b0;
  logic [31:0] mult_i = '0, mcand_i = '0;
  logic        busy_o, done_o;
  logic [31:0] prod_hi_o, prod_lo_o;

  int n_run = 0;
  int n_fail = 0;

  mstep_unit i_mstep_unit (
    .clk_i, .rst_ni, .st_op1_i, .st_mcand_i, .st_n_i, .st_v_i, .st_y_i,
    .st_sum_o, .st_y_o, .st_flags_o, .start_i, .mult_i, .mcand_i,
    .busy_o, .done_o, .prod_hi_o, .prod_lo_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(string req, longint act, longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // behavioural step model: integer arithmetic
  task automatic step_check(logic [31:0] op1, logic [31:0] mc, logic n, logic v, logic [31:0] y);
    longint sh, ad, us, ss;
    longint e_sum, e_y;
    logic [3:0] e_fl;
    st_op1_i = op1; st_mcand_i = mc; st_n_i = n; st_v_i = v; st_y_i = y;
    #1;
    sh = longint'(op1) / 2 + ((n != v) ? 64'sh8000_0000 : 64'sh0);
    ad = (y % 2 == 1) ? longint'(mc) : 64'sh0;
    us = sh + ad;
    e_sum = us % 64'sh1_0000_0000;
    e_y = longint'(y) / 2 + ((op1 % 2 == 1) ? 64'sh8000_0000 : 64'sh0);
    ss = (sh >= 64'sh8000_0000 ? sh - 64'sh1_0000_0000 : sh)
       + (ad >= 64'sh8000_0000 ? ad - 64'sh1_0000_0000 : ad);
    e_fl[3] = (e_sum >= 64'sh8000_0000);
    e_fl[2] = (e_sum == 0);
    e_fl[1] = (ss > 64'sh7FFF_FFFF) || (ss < -64'sh8000_0000);
    e_fl[0] = (us >= 64'sh1_0000_0000);
    check("R1/R2 sum", longint'(st_sum_o), e_sum);
    check("R3 y", longint'(st_y_o), e_y);
    check("R4 N,Z", longint'(st_flags_o[3:2]), longint'(e_fl[3:2]));
    check("R5 V,C", longint'(st_flags_o[1:0]), longint'(e_fl[1:0]));
  endtask

  // per-clock reference of the sequencer
  task automatic run_mul(logic [31:0] mc, logic [31:0] ml, bit poke);
    longint e_prod;
    e_prod = longint'($signed(mc)) * longint'({32'b0, ml});
    @(negedge clk_i);
    start_i = 1'b1; mcand_i = mc; mult_i = ml;
    @(negedge clk_i);
    start_i = 1'b0;
    check("R7 busy after start", longint'(busy_o), 1);
    for (int k = 1; k <= 33; k++) begin
      if (poke && k == 5) begin
        start_i = 1'b1; mcand_i = 32'h1234_5678; mult_i = 32'h0000_0003; // R9
      end
      if (poke && k == 6) start_i = 1'b0;
      @(negedge clk_i);
      check("R7 busy", longint'(busy_o), (k < 33) ? 1 : 0);
      check("R7 done", longint'(done_o), (k == 33) ? 1 : 0);
    end
    check(poke ? "R9 product" : "R8 product", longint'({prod_hi_o, prod_lo_o}), e_prod);
    mcand_i = ~mc; mult_i = ~ml;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i);
      check("R7 done low", longint'(done_o), 0);
      check("R10 hold", longint'({prod_hi_o, prod_lo_o}), e_prod);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 2);
    // R6
    check("R6 busy", longint'(busy_o), 0);
    check("R6 done", longint'(done_o), 0);
    check("R6 product", longint'({prod_hi_o, prod_lo_o}), 0);
    rst_ni = 1'b1;

    // R2 addend suppressed / used
    step_check(32'h0000_0010, 32'hDEAD_BEEF, 1'b0, 1'b0, 32'h0000_0002);
    step_check(32'h0000_0010, 32'h0000_0005, 1'b0, 1'b0, 32'h0000_0003);
    // R1 N xor V fills top
    step_check(32'h0000_0001, 32'h0000_0000, 1'b1, 1'b0, 32'h0000_0000);
    step_check(32'h0000_0001, 32'h0000_0000, 1'b1, 1'b1, 32'h8000_0001);
    // R5 signed overflow
    step_check(32'hFFFF_FFFE, 32'h0000_0001, 1'b0, 1'b0, 32'h0000_0001);
    // R5 carry and R4 zero
    step_check(32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 1'b1, 32'h0000_0001);
    // R5 negative overflow
    step_check(32'h0000_0000, 32'h8000_0000, 1'b1, 1'b0, 32'hFFFF_FFFF);
    step_check(32'h1357_9BDF, 32'h2468_ACE0, 1'b0, 1'b1, 32'h5555_5555);

    run_mul(32'd3, 32'd5, 1'b0);
    run_mul(32'hFFFF_FFF9, 32'hFFFF_FFFF, 1'b0);
    run_mul(32'h8000_0000, 32'hFFFF_FFFF, 1'b0);
    run_mul(32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    run_mul(32'h0000_0000, 32'hABCD_1234, 1'b0);
    run_mul(32'h0001_0001, 32'h8000_0001, 1'b1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule